// File: doc/BRIEF.md
# Single Perceptron Branch Predictor

This block predicts the direction of conditional branches with one shared perceptron. The input vector has three parts. The first is a constant bias input. The second is a parameterised number of low branch-address bits. The third is a parameterised number of global history bits. Each input is read as a single binary value. One signed integer weight is kept per input. The prediction is formed from the weighted sum with no floating point.

The fetch stage presents an address on the predict port and reads the taken decision in the same cycle, because the decision is combinational from the stored state. When a branch resolves, the back end presents its address and actual outcome on the update port for one cycle. The block then recomputes the sum for that branch against the history as it stood, trains the weights at most once, and shifts the outcome into the history.

Top module: `perc_bp`

## Requirements
- R1: After reset all weights and all history bits are zero, so every address is predicted taken.
- R2: Each input bit counts as +1 when it is 1 and as -1 when it is 0. The bias input is always +1. The sum is the total of weight times mapped input, and `pred_taken` is 1 exactly when that sum is greater than or equal to zero.
- R3: On an update, training happens only when the sign of the recomputed sum disagrees with the outcome, or when the absolute value of the sum is at most `THRESH`. Otherwise the weights keep their values.
- R4: When training happens, each weight moves by +1 if its mapped input equals the outcome (+1 for taken, -1 for not taken) and by -1 otherwise. The bias therefore moves toward the outcome.
- R5: A weight never wraps. A step above the largest signed value of `W_BITS` leaves the weight at that largest value, and a step below the smallest signed value leaves it at the smallest.
- R6: The update sum uses the history as it was before the update. After the update, the history is shifted left by one place and the outcome enters at bit 0.
- R7: While `upd_valid` is 0, the values on `upd_pc` and `upd_taken` have no effect on any later prediction.
- R8: All addresses share the same weights, so training on one address can change the prediction for other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | Combinational taken decision for `pred_pc` |
| upd_valid | input | 1 | One resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The properties assume that `upd_valid`, `upd_taken` and `upd_pc` are stable and free of unknown values at each rising clock edge. They also assume that one update describes exactly one resolved branch. The bench changes every input only on the falling edge and holds update pulses to a single cycle. A reference model trains its own copy of the weights and history on the same stream. After each step the bench sweeps every low-address pattern on the predict port. A second instance uses narrow weights and a threshold above any reachable sum, so that repeated training drives weights into saturation.

// File: rtl/perc_pkg.sv
package perc_pkg;

    // Width of a signed sum of n terms, each a signed w-bit value.
    function automatic int sum_width(input int n, input int w);
        return w + $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/perc_dot.sv
module perc_dot #(
    parameter int N  = 9,
    parameter int W  = 8,
    parameter int SW = 13
) (
    input  logic [N-1:0][W-1:0] w,
    input  logic [N-1:0]        x,
    output logic signed [SW-1:0] sum
);
    logic signed [SW-1:0] term [N];

    for (genvar i = 0; i < N; i++) begin : g_term
        logic signed [SW-1:0] ext;
        assign ext     = {{(SW-W){w[i][W-1]}}, w[i]};
        assign term[i] = x[i] ? ext : -ext;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + term[i];
        end
    end
endmodule

// File: rtl/perc_step.sv
module perc_step #(
    parameter int N      = 9,
    parameter int W      = 8,
    parameter int SW     = 13,
    parameter int THRESH = 20
) (
    input  logic [N-1:0][W-1:0] w,
    input  logic [N-1:0]        x,
    input  logic                taken,
    input  logic signed [SW-1:0] sum,
    output logic [N-1:0][W-1:0] w_next,
    output logic                train
);
    localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

    logic          guess;
    logic [SW-1:0] mag;

    assign guess = ~sum[SW-1];
    assign mag   = sum[SW-1] ? SW'(-sum) : SW'(sum);
    assign train = (guess != taken) || (mag <= SW'(THRESH));

    for (genvar i = 0; i < N; i++) begin : g_w
        logic agree;
        assign agree = (x[i] == taken);
        always_comb begin
            w_next[i] = w[i];
            if (train) begin
                if (agree) begin
                    if (w[i] != WMAX) w_next[i] = w[i] + 1'b1;
                end else begin
                    if (w[i] != WMIN) w_next[i] = w[i] - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/perc_bp.sv
module perc_bp #(
    parameter int PC_W   = 32,
    parameter int A_BITS = 4,
    parameter int H_BITS = 4,
    parameter int W_BITS = 8,
    parameter int THRESH = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int N     = 1 + A_BITS + H_BITS;
    localparam int SUM_W = perc_pkg::sum_width(N, W_BITS);

    typedef struct packed {
        logic [H_BITS-1:0]             hist;
        logic [N-1:0][W_BITS-1:0]      w;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0]              px, ux;
    logic signed [SUM_W-1:0]   psum, usum;
    logic [N-1:0][W_BITS-1:0]  w_trained;
    logic                      train_en;

    assign px = {st_q.hist, pred_pc[A_BITS-1:0], 1'b1};
    assign ux = {st_q.hist, upd_pc[A_BITS-1:0], 1'b1};

    perc_dot #(.N(N), .W(W_BITS), .SW(SUM_W)) u_pdot (
        .w(st_q.w), .x(px), .sum(psum)
    );

    perc_dot #(.N(N), .W(W_BITS), .SW(SUM_W)) u_udot (
        .w(st_q.w), .x(ux), .sum(usum)
    );

    perc_step #(.N(N), .W(W_BITS), .SW(SUM_W), .THRESH(THRESH)) u_step (
        .w(st_q.w), .x(ux), .taken(upd_taken), .sum(usum),
        .w_next(w_trained), .train(train_en)
    );

    assign pred_taken = ~psum[SUM_W-1];

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.w    = w_trained;
            st_d.hist = (st_q.hist << 1) | H_BITS'(upd_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/perc_bp_chk.sv
module perc_bp_chk #(
    parameter int H = 4,
    parameter int W = 8,
    parameter int N = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           upd_valid,
    input logic           upd_taken,
    input logic [H-1:0]   hist_q,
    input logic [N*W-1:0] w_q,
    input logic           train_en
);
    localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] bias;
    assign bias = w_q[W-1:0];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(w_q) && $stable(hist_q))); // R7

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist_q == (($past(hist_q) << 1) | H'($past(upd_taken))))); // R6

    AST_NO_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !train_en) |=> $stable(w_q)); // R3

    AST_BIAS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && train_en) |=> ((bias == $past(bias) + 1'b1) || (bias == $past(bias) - 1'b1)
            || ((bias == $past(bias)) && (bias == WMAX || bias == WMIN)))); // R4

    AST_BIAS_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && train_en && upd_taken) |=> ($signed(bias) >= $signed($past(bias)))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && train_en && upd_taken && bias == WMAX) |=> (bias == WMAX)); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && train_en && !upd_taken && bias == WMIN) |=> (bias == WMIN)); // R5
endmodule

bind perc_bp perc_bp_chk #(.H(H_BITS), .W(W_BITS), .N(1 + A_BITS + H_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .hist_q(st_q.hist), .w_q(st_q.w), .train_en(train_en)
);

// File: tb/sim_perc_bp.sv
module sim_perc_bp;
    localparam int PC_W = 32;
    localparam int A = 4;
    localparam int H = 4;
    localparam int NI = 1 + A + H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic [PC_W-1:0] upd_pc = '0;
    logic upd_valid = 1'b0;
    logic upd_taken = 1'b0;
    logic p0, p1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state: [0] mirrors u0 (8-bit weights, threshold 20), [1] mirrors u1 (4-bit, threshold 100)
    int wm [2][NI];
    int wmax [2] = '{127, 7};
    int wmin [2] = '{-128, -8};
    int thr [2] = '{20, 100};
    int hm = 0;

    always #2 clk = ~clk;

    perc_bp #(.PC_W(PC_W), .A_BITS(A), .H_BITS(H), .W_BITS(8), .THRESH(20)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(p0),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    perc_bp #(.PC_W(PC_W), .A_BITS(A), .H_BITS(H), .W_BITS(4), .THRESH(100)) u1 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(p1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int in_val(int k, int pc);
        int b;
        if (k == 0) return 1;
        if (k <= A) b = (pc >> (k - 1)) & 1;
        else        b = (hm >> (k - 1 - A)) & 1;
        return b ? 1 : -1;
    endfunction

    function automatic int msum(int m, int pc);
        int s = 0;
        for (int k = 0; k < NI; k++) s += wm[m][k] * in_val(k, pc);
        return s;
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b (pc=%0d hist=%0d)", req, got, exp, pred_pc, hm);
        end
    endtask

    task automatic sweep(input string req);
        for (int pc = 0; pc < (1 << A); pc++) begin
            pred_pc = PC_W'(pc) | 32'hABCD_0000;
            #1;
            chk(req, p0, msum(0, pc) >= 0);
            chk(req, p1, msum(1, pc) >= 0);
        end
    endtask

    task automatic model_upd(input int pc, input int t);
        int tv = t ? 1 : -1;
        for (int m = 0; m < 2; m++) begin
            int s = msum(m, pc);
            int mag = s < 0 ? -s : s;
            if (((s >= 0) != (t != 0)) || mag <= thr[m]) begin
                for (int k = 0; k < NI; k++) begin
                    if (in_val(k, pc) == tv) begin
                        if (wm[m][k] < wmax[m]) wm[m][k]++;
                    end else begin
                        if (wm[m][k] > wmin[m]) wm[m][k]--;
                    end
                end
            end
        end
        hm = ((hm << 1) | (t & 1)) & ((1 << H) - 1);
    endtask

    task automatic upd(input int pc, input int t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = PC_W'(pc) | 32'h1234_0000;
        upd_taken = t[0];
        @(negedge clk);
        upd_valid = 1'b0;
        model_upd(pc, t);
    endtask

    task automatic t_reset;
        sweep("R1");
    endtask

    task automatic t_ignore;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            upd_pc = PC_W'(i * 5);
            upd_taken = i[0];
            @(negedge clk);
        end
        sweep("R7");
    endtask

    task automatic t_train_shared;
        upd(5, 0);
        sweep("R2");
        upd(5, 0);
        upd(10, 0);
        sweep("R8");
        upd(5, 1);
        sweep("R4");
    endtask

    task automatic t_threshold;
        for (int i = 0; i < 12; i++) begin
            upd(3, 1);
            sweep("R3");
        end
    endtask

    task automatic t_history;
        int pat [8] = '{1, 0, 0, 1, 1, 1, 0, 1};
        for (int i = 0; i < 8; i++) begin
            upd(7, pat[i]);
            sweep("R6");
        end
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 20; i++) upd(0, 1);
        sweep("R5");
        for (int i = 0; i < 20; i++) upd(15, 0);
        sweep("R5");
        upd(15, 0);
        sweep("R5");
    endtask

    task automatic t_mixed;
        int lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            int pc, t;
            lf = ((lf >> 1) | ((((lf >> 0) ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
            pc = lf & 15;
            t = ((lf >> 7) & 1) | ((pc & 1) ^ ((lf >> 11) & 1));
            upd(pc, t & 1);
            if (i % 10 == 0) sweep("R2");
        end
        sweep("R4");
    endtask

    initial begin
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < NI; k++) wm[m][k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ignore();
        t_train_shared();
        t_threshold();
        t_history();
        t_saturate();
        t_mixed();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule